// File: doc/BRIEF.md
# Touch Converter Serial Frame Master

This block is the host side of a four-wire serial link to a touch-screen converter. A single start request makes it latch a channel code, a resolution-mode bit, a single-ended/differential select bit and a two-bit power-down field. It pulls chip-select low and sends a command byte built from those fields, most significant bit first. It then keeps issuing serial clocks until the frame holds exactly 24 of them. From the returning data line it picks out the 12-bit conversion result and presents it together with a one-cycle done pulse.

The serial clock is made from the system clock with a programmable half-period. The 24 clocks go out either as one unbroken run or as three groups of eight. Between groups the clock stays low and chip-select stays low for a programmable idle time. The result does not depend on which of the two forms is used. The clock after the command byte is the converter's hold slot and carries no data. The last three clocks of the frame carry fill bits, and the master throws them away.

Top module: `tsc_host`

## Requirements
- R1: The command byte is sent MSB first over the first 8 rising serial-clock edges, in this order: a constant 1, chan_i[2], chan_i[1], chan_i[0], mode_i, single_i, pwr_i[1], pwr_i[0]. All fields are latched when the start request is accepted.
- R2: Each chip-select-low window holds exactly 24 rising serial-clock edges. sclk_o is low whenever cs_no is high.
- R3: mosi_o changes only at the fall of chip-select or on a falling serial-clock edge. From the 9th rising edge on it is low.
- R4: result_o is formed from the data line sampled at rising edges 10 to 21, MSB first. Samples at rising edges 1 to 9 and 22 to 24 have no effect on it.
- R5: With the latched divider value D, each serial-clock high phase and each low phase lasts D+1 system clocks. The time from the fall of chip-select to the first rising edge is also D+1 system clocks.
- R6: In burst mode, the low phase that follows the 8th falling edge and the one that follows the 16th falling edge are each lengthened by G+1 system clocks, where G is the latched gap value. Chip-select stays low throughout, and the result equals the one from a continuous frame.
- R7: cs_no rises 2*(D+1) system clocks after the 24th falling edge. On that same clock edge done_o goes high for exactly one cycle and result_o takes the new value.
- R8: active_o is high from the cycle after an accepted start until done_o, and low together with done_o. A start request while active_o is high is ignored.
- R9: After reset, cs_no is high and sclk_o, mosi_o, done_o and active_o are low, with result_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| chan_i | input | 3 | Converter input channel code |
| mode_i | input | 1 | Converter resolution-mode bit |
| single_i | input | 1 | Single-ended (1) or differential (0) reference select |
| pwr_i | input | 2 | Converter power-down field |
| burst_i | input | 1 | 1: three groups of 8 clocks; 0: one run of 24 |
| div_i | input | DIV_W | Serial-clock half-period minus one, in system clocks |
| gap_i | input | GAP_W | Extra idle between groups minus one, in system clocks |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip-select, active low |
| mosi_o | output | 1 | Serial data to the converter |
| active_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | 12 | Last conversion result |

## Verification
The bench builds the block with DIV_W=2 and GAP_W=2. This small configuration lets it sweep all four divider settings against all four gap settings in both continuous and burst form, and every command-field bit takes both values along the way. A converter model drives deliberate ones into the hold slot and the fill slots. Extra frames use all-zero, all-one, lone-MSB and lone-LSB results, which expose any slip in the sampling window. Some frames also get a second start request in mid-frame.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Frame geometry fixed by the converter's serial protocol
    localparam int CMD_BITS        = 8;
    localparam int RES_BITS        = 12;
    localparam int FRAME_CLKS      = 24;
    localparam int BURST_CLKS      = 8;
    localparam int HOLD_CLKS       = 1;
    localparam int FIRST_DATA_RISE = CMD_BITS + HOLD_CLKS + 1;
    localparam int LAST_DATA_RISE  = FIRST_DATA_RISE + RES_BITS - 1;
    localparam int CNT_W           = $clog2(FRAME_CLKS + 1);
    localparam int BURST_LSB       = $clog2(BURST_CLKS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_TAIL_A,
        ST_TAIL_B
    } tsc_state_e;

endpackage

// File: rtl/tsc_cmd_pack.sv
module tsc_cmd_pack
    import tsc_pkg::*;
(
    input  logic [2:0]          chan_i,
    input  logic                mode_i,
    input  logic                single_i,
    input  logic [1:0]          pwr_i,
    output logic [CMD_BITS-1:0] cmd_o
);

    // Leading 1 marks the command start for the converter
    assign cmd_o = {1'b1, chan_i, mode_i, single_i, pwr_i};

endmodule

// File: rtl/tsc_half_timer.sv
module tsc_half_timer #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == limit_i);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tsc_rx_shift.sv
module tsc_rx_shift #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clear_i) begin
            data_d = '0;
        end else if (shift_i) begin
            data_d = {data_q[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/tsc_host.sv
module tsc_host
    import tsc_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int GAP_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [2:0]          chan_i,
    input  logic                mode_i,
    input  logic                single_i,
    input  logic [1:0]          pwr_i,
    input  logic                burst_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [GAP_W-1:0]    gap_i,
    input  logic                miso_i,
    output logic                sclk_o,
    output logic                cs_no,
    output logic                mosi_o,
    output logic                active_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o
);

    typedef struct packed {
        tsc_state_e          st;
        logic [CNT_W-1:0]    falls;
        logic [CMD_BITS-1:0] cmd;
        logic                burst;
        logic [DIV_W-1:0]    div;
        logic [GAP_W-1:0]    gap;
        logic [GAP_W-1:0]    gap_left;
        logic                sclk;
        logic                cs_n;
        logic                done;
        logic [RES_BITS-1:0] result;
    } regs_t;

    regs_t q, d;

    logic [CMD_BITS-1:0] cmd_word;
    logic [RES_BITS-1:0] rx_data;
    logic [CNT_W-1:0]    nxt_edge;
    logic                tick;
    logic                run;
    logic                sample;
    logic                clear;

    tsc_cmd_pack u_cmd (
        .chan_i   (chan_i),
        .mode_i   (mode_i),
        .single_i (single_i),
        .pwr_i    (pwr_i),
        .cmd_o    (cmd_word)
    );

    assign run = (q.st == ST_LOW) || (q.st == ST_HIGH) ||
                 (q.st == ST_TAIL_A) || (q.st == ST_TAIL_B);

    tsc_half_timer #(.W(DIV_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .limit_i (q.div),
        .tick_o  (tick)
    );

    tsc_rx_shift #(.W(RES_BITS)) u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .shift_i (sample),
        .bit_i   (miso_i),
        .data_o  (rx_data)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        sample   = 1'b0;
        clear    = 1'b0;
        nxt_edge = q.falls + 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_LOW;
                    d.cs_n  = 1'b0;
                    d.cmd   = cmd_word;
                    d.burst = burst_i;
                    d.div   = div_i;
                    d.gap   = gap_i;
                    d.falls = '0;
                    clear   = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.st   = ST_HIGH;
                    d.sclk = 1'b1;
                    // only the result window feeds the shifter
                    sample = (nxt_edge >= CNT_W'(FIRST_DATA_RISE)) &&
                             (nxt_edge <= CNT_W'(LAST_DATA_RISE));
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.sclk  = 1'b0;
                    d.falls = nxt_edge;
                    d.cmd   = q.cmd << 1;
                    if (nxt_edge == CNT_W'(FRAME_CLKS)) begin
                        d.st = ST_TAIL_A;
                    end else if (q.burst && (nxt_edge[BURST_LSB-1:0] == '0)) begin
                        d.st       = ST_GAP;
                        d.gap_left = q.gap;
                    end else begin
                        d.st = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap_left == '0) begin
                    d.st = ST_LOW;
                end else begin
                    d.gap_left = q.gap_left - 1'b1;
                end
            end
            ST_TAIL_A: begin
                if (tick) begin
                    d.st = ST_TAIL_B;
                end
            end
            ST_TAIL_B: begin
                if (tick) begin
                    d.st     = ST_IDLE;
                    d.cs_n   = 1'b1;
                    d.done   = 1'b1;
                    d.result = rx_data;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o   = q.sclk;
    assign cs_no    = q.cs_n;
    assign mosi_o   = q.cmd[CMD_BITS-1];
    assign active_o = (q.st != ST_IDLE);
    assign done_o   = q.done;
    assign result_o = q.result;

endmodule

// File: rtl/tsc_host_chk.sv
module tsc_host_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sclk_o,
    input logic cs_no,
    input logic mosi_o,
    input logic active_o,
    input logic done_o
);

    logic       sclk_prev_q;
    logic       cs_prev_q;
    logic [5:0] rise_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
            rise_cnt_q  <= '0;
        end else begin
            sclk_prev_q <= sclk_o;
            cs_prev_q   <= cs_no;
            if (cs_no) begin
                rise_cnt_q <= '0;
            end else if (sclk_o && !sclk_prev_q) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    p_idle_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_no |-> !sclk_o);

    p_edge_total_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_no && !cs_prev_q) |-> (rise_cnt_q == 6'd24));

    p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && sclk_prev_q) |-> $stable(mosi_o));

    p_mosi_tail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_no && rise_cnt_q >= 6'd9) |-> !mosi_o);

    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cs_no && !cs_prev_q));

    p_active_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o |-> !cs_no);

    p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !active_o);

endmodule

bind tsc_host tsc_host_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_o   (sclk_o),
    .cs_no    (cs_no),
    .mosi_o   (mosi_o),
    .active_o (active_o),
    .done_o   (done_o)
);

// File: tb/tsc_host_tb_top.sv
module tsc_host_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 2;
    localparam int GAP_W      = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       chan = '0;
    logic             mode = 1'b0;
    logic             single = 1'b0;
    logic [1:0]       pwr = '0;
    logic             burst = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [GAP_W-1:0] gap = '0;
    logic             miso = 1'b1;
    logic             sclk, cs_n, mosi, active, done;
    logic [11:0]      result;

    int checks = 0;
    int errors = 0;

    // converter model / monitor state
    int          hp = 1;
    int          e_gap = 0;
    bit          e_burst = 1'b0;
    logic [11:0] e_res = '0;
    int          m_rises, m_falls, m_low, m_high, m_dur_err, m_mosi_err, m_tail, m_done_cnt, m_idle_err;
    logic [7:0]  m_cmd;
    logic        m_mosi_hi;
    logic        m_sclk_p = 1'b0;
    logic        m_cs_p = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_host #(.DIV_W(DIV_W), .GAP_W(GAP_W)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .chan_i   (chan),
        .mode_i   (mode),
        .single_i (single),
        .pwr_i    (pwr),
        .burst_i  (burst),
        .div_i    (div),
        .gap_i    (gap),
        .miso_i   (miso),
        .sclk_o   (sclk),
        .cs_no    (cs_n),
        .mosi_o   (mosi),
        .active_o (active),
        .done_o   (done),
        .result_o (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_low(input int r);
        if (r == 1) return hp;
        if (e_burst && (r == 9 || r == 17)) return hp + e_gap + 1;
        return hp;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_sclk_p = 1'b0;
            m_cs_p   = 1'b1;
        end else begin
            if (done) m_done_cnt++;
            if (!cs_n && m_cs_p) begin
                m_rises = 0; m_falls = 0; m_cmd = '0; m_low = 0; m_high = 0;
                m_dur_err = 0; m_mosi_err = 0; m_tail = -1; m_idle_err = 0;
                miso = 1'b1;
            end
            if (cs_n && !m_cs_p) m_tail = m_low;
            if (!cs_n) begin
                if (sclk && !m_sclk_p) begin
                    m_rises++;
                    if (m_low != exp_low(m_rises)) m_dur_err++;
                    if (m_rises <= 8) m_cmd = {m_cmd[6:0], mosi};
                    else if (mosi) m_mosi_err++;
                    m_mosi_hi = mosi;
                    m_high = 1;
                end else if (sclk) begin
                    m_high++;
                    if (mosi !== m_mosi_hi) m_mosi_err++;
                end else if (m_sclk_p) begin
                    m_falls++;
                    if (m_high != hp) m_dur_err++;
                    m_low = 1;
                    // hold slot and fill slots get ones on purpose
                    miso = (m_falls >= 9 && m_falls <= 20) ? e_res[20 - m_falls] : 1'b1;
                end else begin
                    m_low++;
                end
            end else if (sclk) begin
                m_idle_err++;
            end
            m_sclk_p = sclk;
            m_cs_p   = cs_n;
        end
    end

    task automatic run_frame(input int ch, input bit md, input bit se, input int pw,
                             input bit bu, input int dv, input int gp,
                             input logic [11:0] res, input bit inject);
        int n;
        logic [7:0] exp_cmd;
        @(negedge clk);
        e_res = res; e_gap = gp; e_burst = bu; hp = dv + 1; m_done_cnt = 0;
        chan = 3'(ch); mode = md; single = se; pwr = 2'(pw);
        burst = bu; div = DIV_W'(dv); gap = GAP_W'(gp); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(active && !cs_n, "R8 active after start", int'(active), 1);
        // scramble inputs: latched copies must govern the frame
        chan = ~chan; mode = ~mode; single = ~single; pwr = ~pwr;
        burst = ~burst; div = ~div; gap = ~gap;
        n = 0;
        while (!done && n < 4000) begin
            start = (inject && n == 30);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(done, "R7 done seen", int'(done), 1);
        check(result == res, "R4 result", int'(result), int'(res));
        check(!active, "R8 active low at done", int'(active), 0);
        check(cs_n, "R7 cs high with done", int'(cs_n), 1);
        @(negedge clk);
        check(!done, "R7 done one cycle", int'(done), 0);
        exp_cmd = {1'b1, 3'(ch), md, se, 2'(pw)};
        check(m_cmd == exp_cmd, "R1 command byte", int'(m_cmd), int'(exp_cmd));
        check(m_rises == 24 && m_falls == 24, "R2 clock count", m_rises, 24);
        check(m_idle_err == 0, "R2 clock idle", m_idle_err, 0);
        check(m_mosi_err == 0, "R3 mosi timing", m_mosi_err, 0);
        if (bu) check(m_dur_err == 0, "R6 burst phase lengths", m_dur_err, 0);
        else    check(m_dur_err == 0, "R5 phase lengths", m_dur_err, 0);
        check(m_tail == 2 * hp, "R7 cs tail", m_tail, 2 * hp);
        repeat (4) @(negedge clk);
        check(m_done_cnt == 1 && !active && cs_n, "R8 single frame", m_done_cnt, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && !sclk && !mosi && !done && !active && result == 12'h000,
              "R9 reset state", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && !active, "R9 idle after reset", int'(cs_n), 1);

        for (int i = 0; i < 32; i++) begin
            run_frame(i % 8, i[3], i[4] ^ i[0], (i ^ (i >> 2)) & 3,
                      i[4], i & 3, (i >> 2) & 3,
                      12'((i * 2731 + 5) & 12'hFFF), (i % 7) == 3);
        end
        run_frame(5, 1'b0, 1'b1, 3, 1'b0, 0, 0, 12'h000, 1'b0);
        run_frame(2, 1'b1, 1'b0, 0, 1'b1, 3, 3, 12'hFFF, 1'b1);
        run_frame(7, 1'b0, 1'b0, 1, 1'b1, 1, 0, 12'h800, 1'b0);
        run_frame(0, 1'b1, 1'b1, 2, 1'b0, 2, 1, 12'h001, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule